// File: doc/BRIEF.md
# Page Table Walk Unit

This unit turns a 32-bit virtual address into a physical address by reading one entry from a single-level page table in memory. A client hands over a virtual address and says whether the access is a read or a write. The unit adds the virtual page number, scaled to a word index, to a table base register. It issues one memory read for the entry, checks the entry's valid and permission bits, and returns one response. The response carries either the physical address or a fault code.

Pages are 4 KB, so the low 12 address bits pass through unchanged and the upper 20 bits select the entry. Each entry is one 32-bit word. The table base is loaded through a one-cycle write strobe. A base write that arrives while a translation is in flight is parked and applied once the unit is idle again, so one translation never reads from two tables. The memory read port accepts a one-cycle request pulse and answers with a one-cycle response pulse after one or more cycles.

Top module: `pt_walker`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `req_ready` is 1, `rsp_valid` is 0 and `mem_req_valid` is 0.
- R2: For each accepted request, `mem_req_valid` is high for exactly one cycle, and `mem_req_addr` equals the table base plus four times the virtual page number (address bits 31:12).
- R3: An entry is laid out as bit 31 valid, bit 30 read permitted, bit 29 write permitted, bit 28 dirty (ignored), and bits PPN_W-1:0 the physical page number. A permitted access returns status 00 and a physical address made of the page number followed by virtual bits 11:0 unchanged. For example, page 0x00004, offset 0x0F3 and page number 0x020C0 give 0x020C00F3.
- R4: An entry with bit 31 clear returns status 01 (page fault) and a physical address of 0, whatever its permission bits hold.
- R5: A valid entry returns status 10 (protection fault) and a physical address of 0 when the access is not permitted. A write is not permitted when bit 29 is clear, and a read is not permitted when bit 30 is clear. Status 11 never appears.
- R6: `req_ready` is low from the cycle after acceptance until the response handshake completes. There is exactly one response per request, and it holds its address and status unchanged while `rsp_ready` is low.
- R7: A base write in a cycle when the unit is idle takes effect at once. A request accepted in that same cycle uses the new base.
- R8: Base writes made while a translation is in progress do not affect that translation. The last such write becomes the base once the unit is idle again.
- R9: Translation is correct for memory latencies of one to three cycles and for the extreme page number 0xFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Unit can accept a request |
| req_vaddr | input | VA_W | Virtual address |
| req_write | input | 1 | 1 = write access, 0 = read access |
| base_wr_en | input | 1 | Table base write strobe |
| base_wr_data | input | VA_W | New table base byte address |
| mem_req_valid | output | 1 | One-cycle entry read request |
| mem_req_addr | output | VA_W | Entry byte address |
| mem_rsp_valid | input | 1 | Entry read data present |
| mem_rsp_data | input | 32 | Entry word |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Client takes the response |
| rsp_paddr | output | PPN_W+OFF_W | Physical address, 0 on a fault |
| rsp_status | output | 2 | 00 ok, 01 page fault, 10 protection fault |

## Verification
A base-register write can coincide with a translation in two ways. It can land in the same cycle that a request is accepted, or in any cycle while an entry read is outstanding or a response is waiting. The bench provokes the first by raising the write strobe together with the request. It provokes the second by issuing two back-to-back writes during a walk, then running a second walk. Its reference model tracks which base each translation must use. It compares every entry address and response against that choice, so using the base early or late, or losing the last deferred write, shows up as a wrong address.

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int VA_W  = 32,
  parameter int OFF_W = 12,
  parameter int PPN_W = 18
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  output logic                   req_ready,
  input  logic [VA_W-1:0]        req_vaddr,
  input  logic                   req_write,
  input  logic                   base_wr_en,
  input  logic [VA_W-1:0]        base_wr_data,
  output logic                   mem_req_valid,
  output logic [VA_W-1:0]        mem_req_addr,
  input  logic                   mem_rsp_valid,
  input  logic [31:0]            mem_rsp_data,
  output logic                   rsp_valid,
  input  logic                   rsp_ready,
  output logic [PPN_W+OFF_W-1:0] rsp_paddr,
  output logic [1:0]             rsp_status
);
  localparam int PA_W  = PPN_W + OFF_W;
  localparam int VPN_W = VA_W - OFF_W;

  typedef enum logic [1:0] {IDLE, FETCH_PTE, RESPOND} st_t;

  st_t             st;
  logic [VA_W-1:0] va_q, base_q, base_pend;
  logic            wr_q, pend_q, issued_q;
  logic [PA_W-1:0] pa_q;
  logic [1:0]      stat_q;
  logic [1:0]      verdict;
  logic [VPN_W-1:0] vpn;

  wire pte_v = mem_rsp_data[31];
  wire pte_r = mem_rsp_data[30];
  wire pte_w = mem_rsp_data[29];
  logic unused_bits;
  assign unused_bits = ^mem_rsp_data[28:PPN_W];

  assign vpn           = va_q[VA_W-1:OFF_W];
  assign req_ready     = (st == IDLE);
  assign mem_req_valid = (st == FETCH_PTE) && !issued_q;
  assign mem_req_addr  = base_q + (VA_W'(vpn) << 2);
  assign rsp_valid     = (st == RESPOND);
  assign rsp_paddr     = pa_q;
  assign rsp_status    = stat_q;

  always_comb begin
    if (!pte_v)                           verdict = 2'b01;
    else if (wr_q ? !pte_w : !pte_r)      verdict = 2'b10;
    else                                  verdict = 2'b00;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st        <= IDLE;
      va_q      <= '0;
      wr_q      <= 1'b0;
      base_q    <= '0;
      base_pend <= '0;
      pend_q    <= 1'b0;
      issued_q  <= 1'b0;
      pa_q      <= '0;
      stat_q    <= 2'b00;
    end else begin
      case (st)
        IDLE: begin
          if (base_wr_en)  base_q <= base_wr_data;
          else if (pend_q) base_q <= base_pend;
          pend_q <= 1'b0;
          if (req_valid) begin
            va_q     <= req_vaddr;
            wr_q     <= req_write;
            issued_q <= 1'b0;
            st       <= FETCH_PTE;
          end
        end
        FETCH_PTE: begin
          if (mem_req_valid) issued_q <= 1'b1;
          if (mem_rsp_valid) begin
            stat_q <= verdict;
            pa_q   <= (verdict == 2'b00) ? {mem_rsp_data[PPN_W-1:0], va_q[OFF_W-1:0]} : '0;
            st     <= RESPOND;
          end
        end
        RESPOND: if (rsp_ready) st <= IDLE;
        default: st <= IDLE;
      endcase
      if (st != IDLE && base_wr_en) begin
        pend_q    <= 1'b1;
        base_pend <= base_wr_data;
      end
    end
  end
endmodule

module pt_walker_chk #(
  parameter int PA_W = 30
) (
  input logic            clk,
  input logic            rst_n,
  input logic            req_valid,
  input logic            req_ready,
  input logic            mem_req_valid,
  input logic            rsp_valid,
  input logic            rsp_ready,
  input logic [PA_W-1:0] rsp_paddr,
  input logic [1:0]      rsp_status
);
  // R1
  idle_after_reset_chk: assert property (@(posedge clk) !rst_n |=> req_ready && !rsp_valid && !mem_req_valid);
  // R2
  single_fetch_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |=> !mem_req_valid);
  // R2
  fetch_only_busy_chk: assert property (@(posedge clk) disable iff (!rst_n) mem_req_valid |-> !req_ready);
  // R4
  fault_zero_addr_chk: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && rsp_status != 2'b00) |-> rsp_paddr == '0);
  // R5
  no_bad_status_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> rsp_status != 2'b11);
  // R6
  rsp_hold_chk: assert property (@(posedge clk) disable iff (!rst_n) (rsp_valid && !rsp_ready) |=> rsp_valid && $stable(rsp_paddr) && $stable(rsp_status));
  // R6
  busy_after_accept_chk: assert property (@(posedge clk) disable iff (!rst_n) (req_valid && req_ready) |=> !req_ready);
  // R6
  no_accept_while_rsp_chk: assert property (@(posedge clk) disable iff (!rst_n) rsp_valid |-> !req_ready);
endmodule

bind pt_walker pt_walker_chk #(.PA_W(PA_W)) u_pt_walker_chk (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
  .mem_req_valid(mem_req_valid), .rsp_valid(rsp_valid), .rsp_ready(rsp_ready),
  .rsp_paddr(rsp_paddr), .rsp_status(rsp_status)
);

// File: tb/test_pt_walker.sv
`timescale 1ns/1ps
module test_pt_walker;
  logic        clk = 0;
  logic        rst_n = 0;
  logic        req_valid = 0, req_write = 0;
  logic [31:0] req_vaddr = 0;
  logic        base_wr_en = 0;
  logic [31:0] base_wr_data = 0;
  logic        mem_req_valid, req_ready, rsp_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 0;
  logic [31:0] mem_rsp_data = 0;
  logic        rsp_ready = 0;
  logic [29:0] rsp_paddr;
  logic [1:0]  rsp_status;

  int compared = 0, mismatched = 0;
  int lat = 1, cnt = 0;
  logic [31:0] mem [logic [31:0]];

  typedef struct { logic [31:0] addr; logic [29:0] pa; logic [1:0] st; } exp_t;
  exp_t q[$];
  bit   m_busy = 0, m_pend = 0;
  logic [31:0] m_base = 0, m_pend_d = 0;

  always #5 clk = ~clk;

  pt_walker i_pt_walker (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_vaddr(req_vaddr), .req_write(req_write), .base_wr_en(base_wr_en),
    .base_wr_data(base_wr_data), .mem_req_valid(mem_req_valid), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data), .rsp_valid(rsp_valid),
    .rsp_ready(rsp_ready), .rsp_paddr(rsp_paddr), .rsp_status(rsp_status)
  );

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    compared++;
    if (!ok) begin
      mismatched++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // reference model: advances on each rising edge using pre-edge values
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = 0; m_pend = 0; m_base = 0; q.delete();
    end else if (!m_busy) begin
      if (base_wr_en) m_base = base_wr_data;
      else if (m_pend) m_base = m_pend_d;
      m_pend = 0;
      if (req_valid) begin
        exp_t e;
        logic [31:0] ent;
        e.addr = m_base + {req_vaddr[31:12], 2'b00};
        ent = rd(e.addr);
        if (!ent[31])                                 begin e.st = 2'b01; e.pa = 0; end
        else if (req_write ? !ent[29] : !ent[30])     begin e.st = 2'b10; e.pa = 0; end
        else                                          begin e.st = 2'b00; e.pa = {ent[17:0], req_vaddr[11:0]}; end
        q.push_back(e);
        m_busy = 1;
      end
    end else begin
      if (base_wr_en) begin m_pend = 1; m_pend_d = base_wr_data; end
      if (rsp_valid && rsp_ready) begin m_busy = 0; void'(q.pop_front()); end
    end
  end

  // compare on every clock, away from the edge
  always @(negedge clk) if (rst_n) begin
    chk(req_ready == !m_busy, "R6 req_ready vs model", req_ready, !m_busy);
    if (mem_req_valid)
      chk(q.size() == 1 && mem_req_addr == q[0].addr, "R2 entry address", mem_req_addr, q.size() ? q[0].addr : 0);
    if (rsp_valid)
      chk(q.size() == 1 && rsp_paddr == q[0].pa && rsp_status == q[0].st, "R6 response vs model",
          {rsp_status, rsp_paddr}, q.size() ? {q[0].st, q[0].pa} : 0);
  end

  // memory with variable latency
  always @(negedge clk) begin
    mem_rsp_valid <= 0;
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) mem_rsp_valid <= 1;
    end
    if (mem_req_valid && rst_n) begin
      cnt = lat;
      mem_rsp_data <= rd(mem_req_addr);
    end
  end

  // mode: 0 none, 1 base write with request, 2 two base writes during walk
  task automatic walk(input logic [31:0] va, input bit wr, input int hold, input int mode,
                      input logic [31:0] ba, input logic [31:0] bb,
                      input logic [29:0] epa, input logic [1:0] est, input string tag);
    logic [29:0] pa0;
    logic [1:0]  st0;
    int guard = 0;
    @(negedge clk);
    req_valid = 1; req_vaddr = va; req_write = wr;
    if (mode == 1) begin base_wr_en = 1; base_wr_data = ba; end
    @(negedge clk);
    req_valid = 0; base_wr_en = 0;
    if (mode == 2) begin
      base_wr_en = 1; base_wr_data = ba;
      @(negedge clk);
      base_wr_data = bb;
      @(negedge clk);
      base_wr_en = 0;
    end
    while (!rsp_valid && guard < 50) begin @(negedge clk); guard++; end
    pa0 = rsp_paddr; st0 = rsp_status;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk(rsp_valid && rsp_paddr == pa0 && rsp_status == st0, "R6 held response", {rsp_status, rsp_paddr}, {st0, pa0});
    end
    chk(rsp_valid && rsp_paddr == epa && rsp_status == est, tag, {rsp_status, rsp_paddr}, {est, epa});
    rsp_ready = 1;
    @(negedge clk);
    rsp_ready = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    // R1
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 reset state", {req_ready, rsp_valid, mem_req_valid}, 3'b100);
    rst_n = 1;
    @(negedge clk);
    chk(req_ready && !rsp_valid && !mem_req_valid, "R1 after reset", {req_ready, rsp_valid, mem_req_valid}, 3'b100);

    @(negedge clk); base_wr_en = 1; base_wr_data = 32'h0001_0000;
    @(negedge clk); base_wr_en = 0;
    mem[32'h0001_0010] = 32'hE000_20C0;
    mem[32'h0001_0014] = 32'hF000_1234;
    mem[32'h0001_0018] = 32'h6000_3333;
    mem[32'h0001_0020] = 32'hC000_0111;
    mem[32'h0001_0024] = 32'h8000_0222;
    mem[32'h0001_0028] = 32'hA000_0333;
    mem[32'h0040_FFFC] = 32'hE003_FFFF;

    lat = 1; walk(32'h0000_40F3, 0, 0, 0, 0, 0, 30'h020C00F3, 2'b00, "R3 example translation");
    lat = 3; walk(32'h0000_5ABC, 1, 2, 0, 0, 0, 30'h01234ABC, 2'b00, "R3 write with dirty set");
    lat = 2; walk(32'h0000_6100, 0, 0, 0, 0, 0, 30'h0, 2'b01, "R4 invalid with rights");
    walk(32'h0000_7000, 1, 1, 0, 0, 0, 30'h0, 2'b01, "R4 unmapped entry");
    lat = 1; walk(32'h0000_8010, 1, 0, 0, 0, 0, 30'h0, 2'b10, "R5 write to read-only");
    walk(32'h0000_8010, 0, 0, 0, 0, 0, 30'h00111010, 2'b00, "R5 read of read-only");
    walk(32'h0000_9000, 0, 0, 0, 0, 0, 30'h0, 2'b10, "R5 no rights");
    walk(32'h0000_A004, 0, 0, 0, 0, 0, 30'h0, 2'b10, "R5 read of write-only");
    lat = 3; walk(32'h0000_A004, 1, 0, 0, 0, 0, 30'h00333004, 2'b00, "R5 write of write-only");
    lat = 2; walk(32'hFFFF_FFFF, 0, 0, 0, 0, 0, 30'h3FFFFFFF, 2'b00, "R9 top page");

    mem[32'h0002_0010] = 32'hE000_0ABC;
    mem[32'h0002_0004] = 32'hE000_0055;
    mem[32'h4000_0004] = 32'hE000_0077;
    lat = 1; walk(32'h0000_4000, 0, 0, 1, 32'h0002_0000, 0, 30'h00ABC000, 2'b00, "R7 base with request");
    lat = 1; walk(32'h0000_1000, 0, 0, 2, 32'h0000_3000, 32'h4000_0000, 30'h00055000, 2'b00, "R8 walk keeps old base");
    lat = 2; walk(32'h0000_1000, 0, 0, 0, 0, 0, 30'h00077000, 2'b00, "R8 last deferred base applied");

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    mismatched++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end
endmodule